// File: doc/BRIEF.md
# Synchronous Serial Receive Port with Clock Generator

This block is the receive side of a synchronous serial port. A DSP uses a port like this to collect conversion results from a serial analog-to-digital converter. The port divides the system clock into a shift clock and derives a periodic frame-sync pulse from that shift clock. It drives both signals out to the converter, whose clock and frame inputs are wired to them.

The converter answers each frame-sync with a word, sent most significant bit first. The port samples one bit on each falling shift-clock edge into a shift register. When the last bit of the word arrives, the finished word is copied into a separate holding register. At that point the port raises a ready flag and pulses an interrupt request for one system clock. Software can take the interrupt or poll the flag. A one-cycle read strobe tells the port the word was taken and clears the flag. If a new word arrives before the old one is read, the overrun flag is set.

Configuration consists of a clock divider, a frame period and a word-length code. It is set while the port is disabled, and the enable input is raised last.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, sclk_o, fsync_o, rx_ready, rx_overrun and rx_irq are 0 and rx_word is 0.
- R2: While enabled, sclk_o has a period of D+1 system clocks, where D is cfg_div (a value of 0 acts as 1). It is high for the first (D+1)/2 cycles (rounded down) and low for the rest. The first shift-clock period starts on the clock edge after cfg_en is seen high.
- R3: fsync_o is high for exactly one whole shift-clock period. It repeats every cfg_frame+1 shift-clock periods, starting with the first period after enable. It changes state only on edges where sclk_o rises.
- R4: sdin is sampled at the system clock edge where sclk_o falls. The bits are taken MSB first, in shift-clock periods 1 through W after the frame-sync period, where W is the word length. Bits sent in the frame-sync period or after period W are ignored.
- R5: The word-length codes are 0=8, 1=12, 2=16, 3=20, 4=24 and 5=32 bits; codes 6 and 7 also mean 32 bits. rx_word holds the word right-aligned in bits W-1..0, with all higher bits 0.
- R6: At the sampling edge of bit W, the word is copied into rx_word and rx_ready rises. rx_irq is high for exactly one system clock, in the same cycle that the new word first appears.
- R7: A rd_strobe cycle with no word completing clears rx_ready and rx_overrun, and leaves rx_word unchanged.
- R8: If a word completes while rx_ready is set and rd_strobe is low, rx_overrun is set and the new word replaces the old one.
- R9: If rd_strobe is high in the cycle a word completes, rx_ready stays set with the new word and rx_overrun is not set.
- R10: With cfg_en low, sclk_o and fsync_o stay low, while rx_word and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Receive enable, raised after configuration |
| cfg_div | input | DIV_W | Shift-clock divider D (period D+1 clocks) |
| cfg_frame | input | FRM_W | Frame period minus one, in shift clocks |
| cfg_wlen | input | 3 | Word-length code |
| sdin | input | 1 | Serial data from the converter |
| rd_strobe | input | 1 | One-cycle read of the holding register |
| sclk_o | output | 1 | Generated shift clock |
| fsync_o | output | 1 | Generated frame sync |
| rx_word | output | 32 | Received word holding register |
| rx_ready | output | 1 | Word-available flag |
| rx_overrun | output | 1 | Word lost before being read |
| rx_irq | output | 1 | One-cycle receive interrupt request |

## Verification
The bench sweeps every word-length code against several dividers, including 0, 1 and odd values. An off-by-one in the shift-clock high time or period would show up as a wrong measured duty cycle, or as bits taken from the wrong period. The frame is set both to the minimum length and to a longer one. Data bits outside the word window are driven high, so a design that samples the frame-sync period or shifts past W leaves nonzero upper bits or a shifted word. Overrun is tested with two words left unread, and a read strobe is placed in exactly the cycle a word completes. A design that gave the read priority over the arrival would drop the ready flag or falsely set overrun.

// File: rtl/srx_pkg.sv
package srx_pkg;

  localparam int unsigned WMAX = 32;
  localparam int unsigned WB_W = 6;

  // Word-length code to bit count; unused codes map to the widest word.
  function automatic logic [WB_W-1:0] word_bits(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd8;
      3'd1:    return 6'd12;
      3'd2:    return 6'd16;
      3'd3:    return 6'd20;
      3'd4:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Right-aligned mask of the given number of bits.
  function automatic logic [WMAX-1:0] word_mask(input logic [WB_W-1:0] bits);
    if (int'(bits) >= int'(WMAX)) return '1;
    return (32'd1 << bits) - 32'd1;
  endfunction

endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_tick,
  output logic             rise_tick
);

  // Divider zero cannot make two edges, so it behaves as one.
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
    return (d == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : d;
  endfunction

  // Number of system clocks the shift clock spends high.
  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] p;
    p = {1'b0, eff_div(d)} + 1'b1;
    return p[DIV_W:1];
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  logic [DIV_W-1:0] hi;

  assign last = eff_div(div);
  assign hi   = high_len(div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!en)          cnt <= '0;
    else if (cnt == last)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign sclk      = en && (cnt < hi);
  assign fall_tick = en && (cnt == hi - 1'b1);
  assign rise_tick = en && (cnt == last);

endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int unsigned FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic [FRM_W-1:0] frame_len,
  input  logic [5:0]       wbits,
  output logic             fsync,
  output logic             sample,
  output logic             done
);

  logic [FRM_W-1:0] fr_cnt;
  logic             in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fr_cnt <= '0;
    else if (!en)       fr_cnt <= '0;
    else if (rise_tick) fr_cnt <= (fr_cnt == frame_len) ? '0 : fr_cnt + 1'b1;
  end

  assign in_window = (fr_cnt != '0) && (int'(fr_cnt) <= int'(wbits));
  assign fsync     = en && (fr_cnt == '0);
  assign sample    = fall_tick && in_window;
  assign done      = fall_tick && (int'(fr_cnt) == int'(wbits));

endmodule

// File: rtl/srx_rxpath.sv
module srx_rxpath
  import srx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample,
  input  logic            done,
  input  logic            sdin,
  input  logic            rd,
  input  logic [WMAX-1:0] wmask,
  output logic [WMAX-1:0] word,
  output logic            ready,
  output logic            ovr,
  output logic            irq
);

  logic [WMAX-1:0] shreg;
  logic [WMAX-1:0] shreg_nx;

  assign shreg_nx = {shreg[WMAX-2:0], sdin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shreg <= '0;
    else if (sample) shreg <= shreg_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      ready <= 1'b0;
      ovr   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= done;
      if (done) begin
        word  <= shreg_nx & wmask;
        ready <= 1'b1;
        ovr   <= rd ? 1'b0 : (ovr | ready);
      end else if (rd) begin
        ready <= 1'b0;
        ovr   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import srx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [FRM_W-1:0] cfg_frame,
  input  logic [2:0]       cfg_wlen,
  input  logic             sdin,
  input  logic             rd_strobe,
  output logic             sclk_o,
  output logic             fsync_o,
  output logic [WMAX-1:0]  rx_word,
  output logic             rx_ready,
  output logic             rx_overrun,
  output logic             rx_irq
);

  logic            en_q;
  logic            fall_w;
  logic            rise_w;
  logic            sample_w;
  logic            done_w;
  logic [WB_W-1:0] wbits_w;
  logic [WMAX-1:0] mask_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= cfg_en;
  end

  assign wbits_w = word_bits(cfg_wlen);
  assign mask_w  = word_mask(wbits_w);

  srx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .div       (cfg_div),
    .sclk      (sclk_o),
    .fall_tick (fall_w),
    .rise_tick (rise_w)
  );

  srx_framer #(.FRM_W(FRM_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en_q),
    .rise_tick (rise_w),
    .fall_tick (fall_w),
    .frame_len (cfg_frame),
    .wbits     (wbits_w),
    .fsync     (fsync_o),
    .sample    (sample_w),
    .done      (done_w)
  );

  srx_rxpath u_rxpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample_w),
    .done   (done_w),
    .sdin   (sdin),
    .rd     (rd_strobe),
    .wmask  (mask_w),
    .word   (rx_word),
    .ready  (rx_ready),
    .ovr    (rx_overrun),
    .irq    (rx_irq)
  );

endmodule

// File: rtl/srx_port_chk.sv
module srx_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en_q,
  input logic        sclk_o,
  input logic        fsync_o,
  input logic        sample_w,
  input logic        done_w,
  input logic        rd_strobe,
  input logic [31:0] rx_word,
  input logic        rx_ready,
  input logic        rx_overrun,
  input logic        rx_irq,
  input logic [31:0] mask_w
);

  AST_SAMPLE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) sample_w |=> $fell(sclk_o)); // R4

  AST_FSYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) (en_q && $past(en_q) && !$stable(fsync_o)) |-> $rose(sclk_o)); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (en_q && rx_ready) |-> ((rx_word & ~mask_w) == 32'd0)); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |=> !rx_irq); // R6

  AST_IRQ_READY: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> rx_ready); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_strobe && !done_w) |=> (!rx_ready && !rx_overrun)); // R7

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) (done_w && rx_ready && !rd_strobe) |=> rx_overrun); // R8

  AST_READ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) (done_w && rd_strobe) |=> (rx_ready && !rx_overrun)); // R9

endmodule

bind serial_rx_port srx_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .sclk_o     (sclk_o),
  .fsync_o    (fsync_o),
  .sample_w   (sample_w),
  .done_w     (done_w),
  .rd_strobe  (rd_strobe),
  .rx_word    (rx_word),
  .rx_ready   (rx_ready),
  .rx_overrun (rx_overrun),
  .rx_irq     (rx_irq),
  .mask_w     (mask_w)
);

// File: tb/serial_rx_port_tb.sv
module serial_rx_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [7:0]  cfg_frame = 8'd16;
  logic [2:0]  cfg_wlen = 3'd0;
  logic        sdin = 1'b1;
  logic        rd_strobe = 1'b0;
  logic        sclk_o, fsync_o, rx_ready, rx_overrun, rx_irq;
  logic [31:0] rx_word;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int cur_w   = 8;
  int cfg_id  = 0;

  serial_rx_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_div(cfg_div),
    .cfg_frame(cfg_frame), .cfg_wlen(cfg_wlen), .sdin(sdin),
    .rd_strobe(rd_strobe), .sclk_o(sclk_o), .fsync_o(fsync_o),
    .rx_word(rx_word), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
    .rx_irq(rx_irq)
  );

  always #2 clk = ~clk;

  function automatic int wlen_of(input int code);
    case (code)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

  function automatic logic [31:0] pattern(input int f, input int s);
    logic [31:0] v;
    if (f == 2 && (s % 3) == 0) return 32'd0;
    v = (32'(s) * 32'h0100_0193) ^ (32'(f + 1) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
    return v;
  endfunction

  function automatic logic [31:0] expect_word(input int f);
    return pattern(f, cfg_id) & mask_of(cur_w);
  endfunction

  // Converter model: changes data just after each shift-clock rise.
  logic        sclk_prev = 1'b0;
  int          idx = 0;
  int          frame_no = -1;
  always @(posedge clk) begin
    logic [31:0] pw;
    #1;
    if (!cfg_en) begin
      frame_no  = -1;
      idx       = 0;
      sdin      = 1'b1;
      sclk_prev = 1'b0;
    end else begin
      if (sclk_o && !sclk_prev) begin
        if (fsync_o) begin
          frame_no = frame_no + 1;
          idx = 0;
        end else begin
          idx = idx + 1;
        end
        pw = pattern(frame_no, cfg_id);
        if (idx >= 1 && idx <= cur_w) sdin = pw[cur_w - idx];
        else sdin = 1'b1;
      end
      sclk_prev = sclk_o;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wait_irq(input string req);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rx_irq && n < 5000);
    check(rx_irq, req, 32'(rx_irq), 32'd1);
  endtask

  task automatic do_read(input logic [31:0] held);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check(!rx_ready && !rx_overrun, "R7 flags after read", {rx_ready, rx_overrun}, 32'd0);
    check(rx_word == held, "R7 word kept after read", rx_word, held);
  endtask

  task automatic wait_fsync();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fsync_o && n < 5000);
  endtask

  task automatic run_cfg(input int d, input int code, input int extra);
    int de, per, hi, frm, h, f, c;
    cfg_div   = 8'(d);
    cfg_wlen  = 3'(code);
    cur_w     = wlen_of(code);
    frm       = cur_w + extra;
    cfg_frame = 8'(frm);
    cfg_id++;
    de  = (d == 0) ? 1 : d;
    per = de + 1;
    hi  = per / 2;
    @(negedge clk);
    cfg_en = 1'b1;
    wait_fsync();
    h = 0; f = 0;
    for (int i = 0; i < per; i++) begin
      h += int'(sclk_o);
      f += int'(fsync_o);
      @(negedge clk);
    end
    check(h == hi, "R2 shift clock high time", 32'(h), 32'(hi));
    check(f == per, "R3 frame sync width", 32'(f), 32'(per));
    check(sclk_o && !fsync_o, "R2 second period starts high", {sclk_o, fsync_o}, 32'd2);
    c = per;
    while (!fsync_o && c < 5000) begin
      @(negedge clk);
      c++;
    end
    check(c == (frm + 1) * per, "R3 frame period", 32'(c), 32'((frm + 1) * per));
    check(rx_ready && rx_word == expect_word(0), "R5 first word", rx_word, expect_word(0));
    do_read(expect_word(0));
    for (int k = 1; k <= 2; k++) begin
      wait_irq("R6 interrupt raised");
      check(rx_ready, "R6 ready with interrupt", 32'(rx_ready), 32'd1);
      check(rx_word == expect_word(k), "R4 R5 word value", rx_word, expect_word(k));
      @(negedge clk);
      check(!rx_irq, "R6 interrupt one cycle", 32'(rx_irq), 32'd0);
      do_read(expect_word(k));
    end
    cfg_en = 1'b0;
    repeat (3) @(negedge clk);
    check(!sclk_o && !fsync_o, "R10 outputs quiet", {sclk_o, fsync_o}, 32'd0);
    check(rx_word == expect_word(2) && !rx_ready, "R10 word held", rx_word, expect_word(2));
  endtask

  task automatic run_overrun();
    int m;
    cfg_div   = 8'd1;
    cfg_wlen  = 3'd0;
    cur_w     = 8;
    cfg_frame = 8'd8;
    cfg_id++;
    @(negedge clk);
    cfg_en = 1'b1;
    wait_irq("R8 first word");
    wait_irq("R8 second word");
    check(rx_overrun && rx_ready, "R8 overrun set", {rx_overrun, rx_ready}, 32'd3);
    check(rx_word == expect_word(1), "R8 newer word kept", rx_word, expect_word(1));
    do_read(expect_word(1));
    wait_irq("R9 third word");
    wait_fsync();
    m = 8 * 2 + 1;
    repeat (m - 1) @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    check(rx_irq && rx_ready, "R9 ready kept on coincident read", {rx_irq, rx_ready}, 32'd3);
    check(!rx_overrun, "R9 no overrun on coincident read", 32'(rx_overrun), 32'd0);
    check(rx_word == expect_word(3), "R9 word value", rx_word, expect_word(3));
    do_read(expect_word(3));
    cfg_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int divs[5] = '{0, 1, 2, 3, 5};
    repeat (5) @(negedge clk);
    check(!sclk_o && !fsync_o && !rx_ready && !rx_overrun && !rx_irq && rx_word == 32'd0,
          "R1 reset state", {rx_word[27:0], sclk_o, fsync_o, rx_ready, rx_irq}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!sclk_o && !fsync_o, "R10 idle while disabled", {sclk_o, fsync_o}, 32'd0);
    for (int di = 0; di < 5; di++) begin
      for (int code = 0; code < 8; code++) begin
        run_cfg(divs[di], code, (code % 2 == 1) ? 3 : 0);
      end
    end
    run_overrun();
    finish_run();
  end

endmodule